// File: doc/BRIEF.md
# Processor Status Flags and Conditional Branch Resolver

This block keeps the eight-bit status word of a small processor core and resolves the instructions that act on it directly. Each cycle it may take a masked flag update from the arithmetic unit. It may also take one decoded command: branch when a selected flag is set, branch when it is clear, force one flag to 1 or 0, copy one register bit into the transfer flag T, or write T into one register bit.

For branches, the block tests the flag chosen by a three-bit index and reports whether the branch is taken. It also computes the target address from the current program counter and a signed seven-bit offset, and reports how many cycles the instruction takes. Every named conditional branch is one of the two generic commands with a fixed index. At the sign index the test is made on the exclusive OR of the negative and overflow flags, which gives the signed greater-or-equal and less-than branches. The fetch pipeline, skip instructions, interrupt entry and the stack sit outside this block.

Top module: `flag_branch_unit`

## Requirements
- R1: After a synchronous active-low reset the status word reads 0x00.
- R2: At each clock edge, every status bit whose `alu_mask_i` bit is 1 takes the matching `alu_flags_i` bit, and every bit whose mask bit is 0 keeps its value (unless a command below overrides it).
- R3: Bit positions from 7 down to 0 are: interrupt enable, T, half carry, sign, overflow, negative, zero, carry. `flag_idx_i` selects the bit at that position for every command.
- R4: Command code 1 (branch if set) is taken when the selected flag is 1. Command code 2 (branch if clear) is taken when the selected flag is 0. This applies to indices 0 to 3 and 5 to 7.
- R5: With `SIGN_FROM_NV`=1, a branch at index 4 tests overflow (bit 3) XOR negative (bit 2), not the stored sign bit. Branch-if-clear at index 4 is therefore signed greater-or-equal, and branch-if-set is signed less-than.
- R6: `target_o` equals `pc_i` + sign-extended `offset_i` + 1, modulo 2^`PC_W`. The offset is seven-bit two's complement.
- R7: `cycles_o` is 2 for a taken branch and 1 for every other case.
- R8: Command code 3 forces the selected status bit to 1 at the next edge, and code 4 forces it to 0. Other bits follow R2.
- R9: When a flag force (codes 3 and 4) or a bit store (code 5) lands on a bit that the ALU mask also writes in the same cycle, the command's value wins.
- R10: Command code 5 (bit store) writes `operand_i[flag_idx_i]` into T (bit 6) at the next edge.
- R11: `bitload_o` equals `operand_i` with bit `flag_idx_i` replaced by T. Command code 6 (bit load) leaves every status bit unchanged.
- R12: `taken_o` is 0 for command codes 0, 3, 4, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Command code (0 none, 1 branch-if-set, 2 branch-if-clear, 3 force 1, 4 force 0, 5 bit store, 6 bit load) |
| flag_idx_i | input | 3 | Flag index or register bit number |
| alu_mask_i | input | 8 | Per-bit write enable for ALU flag results |
| alu_flags_i | input | 8 | Flag values from the ALU |
| offset_i | input | 7 | Signed branch offset |
| pc_i | input | PC_W | Current program counter |
| operand_i | input | 8 | Register byte for bit store and bit load |
| status_o | output | 8 | Status word |
| taken_o | output | 1 | Branch is taken |
| target_o | output | PC_W | Branch target address |
| cycles_o | output | 2 | Cycle count of the current instruction |
| bitload_o | output | 8 | Register byte after bit load |

## Verification
The bench builds the block with `PC_W`=8 and the sign-from-NV variant enabled. With an eight-bit program counter, every pairing of program counter and offset can be swept, so both wrap directions of the target adder are checked exhaustively. Every one of the 256 status words is loaded through the ALU mask and tested under both branch commands at all eight indices, so the XOR condition at index 4 meets every combination of the negative, overflow and stored sign bits. Force, store and load commands are swept over every index, both against an idle ALU and against a full-mask ALU write of the opposite value.

// File: rtl/flag_branch_pkg.sv
// Package: shared command encoding and status bit positions for the
// flag/branch unit. Assumes an eight-bit status word.
package flag_branch_pkg;

    localparam int FLAG_W = 8;
    localparam int IDX_W  = 3;

    // Status bit positions (behavioural: index decoding depends on them)
    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_N = 2;
    localparam int POS_V = 3;
    localparam int POS_S = 4;
    localparam int POS_H = 5;
    localparam int POS_T = 6;
    localparam int POS_I = 7;

    typedef enum logic [2:0] {
        CMD_NONE      = 3'd0,
        CMD_BR_SET    = 3'd1,
        CMD_BR_CLR    = 3'd2,
        CMD_FLAG_ONE  = 3'd3,
        CMD_FLAG_ZERO = 3'd4,
        CMD_BIT_STORE = 3'd5,
        CMD_BIT_LOAD  = 3'd6,
        CMD_SPARE     = 3'd7
    } flag_cmd_e;

endpackage

// File: rtl/fbu_bit_xfer.sv
// Module: bit transfer path between a register byte and the T flag.
// Extracts the bit to store into T and builds the byte for a bit load.
// Assumes idx selects a bit of an eight-bit operand; purely combinational
// apart from the clocked assertions.
module fbu_bit_xfer
    import flag_branch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [FLAG_W-1:0] operand,
    input  logic              t_bit,
    output logic              store_bit,
    output logic [FLAG_W-1:0] loaded
);

    // Pick the operand bit that a bit store copies into T
    always_comb begin
        store_bit = operand[idx];
    end

    // Replace the addressed operand bit with T for a bit load
    always_comb begin
        loaded      = operand;
        loaded[idx] = t_bit;
    end

    // R11: only the addressed bit may differ from the operand
    a_r11_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (((loaded ^ operand) & ~(FLAG_W'(1) << idx)) == '0));

    // R11: the addressed bit carries T
    a_r11_t_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded[idx] == t_bit));

endmodule

// File: rtl/fbu_branch_eval.sv
// Module: branch condition test, target adder and cycle count.
// Assumes the status word is the registered value of the current cycle
// and that OFS_W <= PC_W. SIGN_FROM_NV selects whether index 4 tests
// the live N^V combination or the stored sign bit.
module fbu_branch_eval
    import flag_branch_pkg::*;
#(
    parameter int PC_W         = 10,
    parameter int OFS_W        = 7,
    parameter bit SIGN_FROM_NV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  flag_cmd_e         cmd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [FLAG_W-1:0] status,
    input  logic [PC_W-1:0]   pc,
    input  logic [OFS_W-1:0]  offset,
    output logic              taken,
    output logic [PC_W-1:0]   target,
    output logic [1:0]        cycles
);

    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    logic sel_bit;
    logic is_branch;
    logic [PC_W-1:0] ofs_ext;

    generate
        if (SIGN_FROM_NV) begin : g_nv_sign
            // Index 4 uses the signed comparison result N xor V
            always_comb begin
                if (idx == IDX_W'(POS_S))
                    sel_bit = status[POS_V] ^ status[POS_N];
                else
                    sel_bit = status[idx];
            end
        end else begin : g_stored_sign
            // Every index reads the stored status bit
            always_comb begin
                sel_bit = status[idx];
            end
        end
    endgenerate

    // Decide whether the command is a branch and whether it is taken
    always_comb begin
        is_branch = (cmd == CMD_BR_SET) || (cmd == CMD_BR_CLR);
        taken     = ((cmd == CMD_BR_SET) &&  sel_bit) ||
                    ((cmd == CMD_BR_CLR) && !sel_bit);
    end

    // Sign-extend the offset and form PC + k + 1 modulo the PC width
    always_comb begin
        ofs_ext = PC_W'($signed(offset));
        target  = pc + ofs_ext + PC_ONE;
    end

    // Taken branches cost two cycles, everything else one
    always_comb begin
        cycles = taken ? 2'd2 : 2'd1;
    end

    // R7: a taken branch reports two cycles, otherwise one
    a_r7_taken_two: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (cycles == 2'd2));
    a_r7_idle_one: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> (cycles == 2'd1));

    // R12: commands that are not branches never take
    a_r12_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        !is_branch |-> !taken);

endmodule

// File: rtl/fbu_flag_reg.sv
// Module: the status word register. Merges masked ALU results with the
// explicit flag commands; an explicit command wins on the bit it targets.
// Assumes one command per cycle; reset is synchronous and active low.
module fbu_flag_reg
    import flag_branch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  flag_cmd_e         cmd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [FLAG_W-1:0] alu_mask,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic              store_bit,
    output logic [FLAG_W-1:0] status
);

    logic [FLAG_W-1:0] status_nxt;

    // Compute the next status word: ALU merge, then command override
    always_comb begin
        status_nxt = (status & ~alu_mask) | (alu_flags & alu_mask);
        case (cmd)
            CMD_FLAG_ONE:  status_nxt[idx]   = 1'b1;
            CMD_FLAG_ZERO: status_nxt[idx]   = 1'b0;
            CMD_BIT_STORE: status_nxt[POS_T] = store_bit;
            default: ;
        endcase
    end

    // Register the status word
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= status_nxt;
    end

    // R8: a force-to-one leaves the addressed bit at 1
    a_r8_force_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_FLAG_ONE) |=> (status[$past(idx)] == 1'b1));

    // R8: a force-to-zero leaves the addressed bit at 0
    a_r8_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_FLAG_ZERO) |=> (status[$past(idx)] == 1'b0));

    // R10: a bit store lands in T
    a_r10_store_t: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BIT_STORE) |=> (status[POS_T] == $past(store_bit)));

    // R11: a bit load with no ALU write leaves the word alone
    a_r11_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_BIT_LOAD) && (alu_mask == '0)) |=> $stable(status));

    // R2: with no command, masked bits follow the ALU values
    a_r2_alu_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NONE) |=>
            (((status ^ $past(alu_flags)) & $past(alu_mask)) == '0));

endmodule

// File: rtl/flag_branch_unit.sv
// Module: top of the status flag and conditional branch resolver.
// Connects the status register, the branch evaluator and the bit
// transfer path. Branch outputs are combinational from the registered
// status word and the current command.
module flag_branch_unit
    import flag_branch_pkg::*;
#(
    parameter int PC_W         = 10,
    parameter int OFS_W        = 7,
    parameter bit SIGN_FROM_NV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [2:0]        flag_idx_i,
    input  logic [7:0]        alu_mask_i,
    input  logic [7:0]        alu_flags_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [7:0]        operand_i,
    output logic [7:0]        status_o,
    output logic              taken_o,
    output logic [PC_W-1:0]   target_o,
    output logic [1:0]        cycles_o,
    output logic [7:0]        bitload_o
);

    flag_cmd_e         cmd;
    logic              store_bit;
    logic [FLAG_W-1:0] status;

    // Decode the raw command bits into the shared encoding
    always_comb begin
        cmd = flag_cmd_e'(cmd_i);
    end

    fbu_bit_xfer i_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (flag_idx_i),
        .operand   (operand_i),
        .t_bit     (status[POS_T]),
        .store_bit (store_bit),
        .loaded    (bitload_o)
    );

    fbu_flag_reg i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .idx       (flag_idx_i),
        .alu_mask  (alu_mask_i),
        .alu_flags (alu_flags_i),
        .store_bit (store_bit),
        .status    (status)
    );

    fbu_branch_eval #(
        .PC_W         (PC_W),
        .OFS_W        (OFS_W),
        .SIGN_FROM_NV (SIGN_FROM_NV)
    ) i_branch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .idx    (flag_idx_i),
        .status (status),
        .pc     (pc_i),
        .offset (offset_i),
        .taken  (taken_o),
        .target (target_o),
        .cycles (cycles_o)
    );

    // Expose the status word
    always_comb begin
        status_o = status;
    end

endmodule

// File: tb/test_flag_branch_unit.sv
module test_flag_branch_unit;

    localparam int PC_W  = 8;
    localparam int OFS_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cmd_i = '0;
    logic [2:0]        flag_idx_i = '0;
    logic [7:0]        alu_mask_i = '0;
    logic [7:0]        alu_flags_i = '0;
    logic [OFS_W-1:0]  offset_i = '0;
    logic [PC_W-1:0]   pc_i = '0;
    logic [7:0]        operand_i = '0;
    logic [7:0]        status_o;
    logic              taken_o;
    logic [PC_W-1:0]   target_o;
    logic [1:0]        cycles_o;
    logic [7:0]        bitload_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    flag_branch_unit #(.PC_W(PC_W), .OFS_W(OFS_W), .SIGN_FROM_NV(1'b1)) i_flag_branch_unit (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .flag_idx_i(flag_idx_i),
        .alu_mask_i(alu_mask_i), .alu_flags_i(alu_flags_i), .offset_i(offset_i),
        .pc_i(pc_i), .operand_i(operand_i), .status_o(status_o), .taken_o(taken_o),
        .target_o(target_o), .cycles_o(cycles_o), .bitload_o(bitload_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Load a full status word through the ALU mask (R2)
    task automatic load_status(input logic [7:0] v);
        @(negedge clk);
        cmd_i = 3'd0; alu_mask_i = 8'hFF; alu_flags_i = v;
        @(negedge clk);
        alu_mask_i = '0; alu_flags_i = '0;
        check("R2 load", int'(status_o), int'(v));
    endtask

    // Apply one command for one clock edge, then return to idle
    task automatic apply(input logic [2:0] c, input logic [2:0] ix,
                         input logic [7:0] m, input logic [7:0] f,
                         input logic [7:0] op);
        @(negedge clk);
        cmd_i = c; flag_idx_i = ix; alu_mask_i = m; alu_flags_i = f; operand_i = op;
        @(negedge clk);
        cmd_i = 3'd0; alu_mask_i = '0; alu_flags_i = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] exp_v;
        repeat (3) @(negedge clk);
        // R1: reset value
        check("R1 reset", int'(status_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(status_o), 0);

        // R2 partial mask: only masked bits move
        load_status(8'hA5);
        apply(3'd0, 3'd0, 8'h0F, 8'h3C, 8'h00);
        check("R2 partial mask", int'(status_o), int'(8'hAC));

        // R3 R4 R5 R7: every status word, both branch commands, all indices
        for (int v = 0; v < 256; v++) begin
            load_status(8'(v));
            for (int ix = 0; ix < 8; ix++) begin
                for (int c = 1; c <= 2; c++) begin
                    logic [7:0] vv;
                    logic bsel;
                    logic exp_t;
                    vv = 8'(v);
                    bsel = (ix == 4) ? (vv[3] ^ vv[2]) : vv[ix];
                    exp_t = (c == 1) ? bsel : !bsel;
                    @(negedge clk);
                    cmd_i = 3'(c); flag_idx_i = 3'(ix);
                    #1;
                    if (ix == 4) check("R5 signed test", int'(taken_o), int'(exp_t));
                    else check("R4 flag test", int'(taken_o), int'(exp_t));
                    check("R7 cycles", int'(cycles_o), exp_t ? 2 : 1);
                end
            end
            @(negedge clk);
            cmd_i = 3'd0;
            check("R4 branch keeps status", int'(status_o), v);
        end

        // R12: non-branch commands never take
        load_status(8'hFF);
        for (int c = 0; c < 8; c++) begin
            if (c == 1 || c == 2) continue;
            for (int ix = 0; ix < 8; ix++) begin
                @(negedge clk);
                cmd_i = 3'(c); flag_idx_i = 3'(ix);
                #1;
                check("R12 not taken", int'(taken_o), 0);
                check("R7 one cycle", int'(cycles_o), 1);
                cmd_i = 3'd0;
            end
            load_status(8'hFF);
        end

        // R6: exhaustive target sweep
        for (int p = 0; p < 256; p++) begin
            for (int k = 0; k < 128; k++) begin
                int ks;
                ks = (k >= 64) ? k - 128 : k;
                @(negedge clk);
                pc_i = PC_W'(p); offset_i = OFS_W'(k); cmd_i = 3'd1;
                #1;
                check("R6 target", int'(target_o), (p + ks + 1) & 255);
            end
        end
        cmd_i = 3'd0;

        // R8 R9: force one / zero, alone and against opposite ALU writes
        for (int ix = 0; ix < 8; ix++) begin
            load_status(8'h00);
            apply(3'd3, 3'(ix), 8'h00, 8'h00, 8'h00);
            check("R8 force one", int'(status_o), 1 << ix);
            load_status(8'hFF);
            apply(3'd4, 3'(ix), 8'h00, 8'h00, 8'h00);
            check("R8 force zero", int'(status_o), 8'hFF & ~(1 << ix));
            load_status(8'h00);
            apply(3'd3, 3'(ix), 8'hFF, 8'h00, 8'h00);
            check("R9 force one beats ALU", int'(status_o), 1 << ix);
            load_status(8'h00);
            apply(3'd4, 3'(ix), 8'hFF, 8'hFF, 8'h00);
            check("R9 force zero beats ALU", int'(status_o), 8'hFF & ~(1 << ix));
        end

        // R10 R9: bit store into T
        for (int ix = 0; ix < 8; ix++) begin
            for (int pat = 0; pat < 2; pat++) begin
                logic [7:0] op;
                op = (pat == 0) ? 8'h5A : 8'hA5;
                load_status(8'h99);
                apply(3'd5, 3'(ix), 8'h00, 8'h00, op);
                exp_v = 8'h99; exp_v[6] = op[ix];
                check("R10 bit store", int'(status_o), int'(exp_v));
                load_status(8'h00);
                apply(3'd5, 3'(ix), 8'h40, {1'b0, ~op[ix], 6'b0}, op);
                exp_v = 8'h00; exp_v[6] = op[ix];
                check("R9 store beats ALU", int'(status_o), int'(exp_v));
            end
        end

        // R11: bit load output and no status change
        for (int tv = 0; tv < 2; tv++) begin
            logic [7:0] base;
            base = (tv == 1) ? 8'h40 : 8'hBF;
            for (int ix = 0; ix < 8; ix++) begin
                for (int pat = 0; pat < 2; pat++) begin
                    logic [7:0] op;
                    op = (pat == 0) ? 8'h00 : 8'hFF;
                    load_status(base);
                    @(negedge clk);
                    cmd_i = 3'd6; flag_idx_i = 3'(ix); operand_i = op;
                    #1;
                    exp_v = op; exp_v[ix] = 1'(tv);
                    check("R11 bit load byte", int'(bitload_o), int'(exp_v));
                    @(negedge clk);
                    cmd_i = 3'd0;
                    check("R11 status unchanged", int'(status_o), int'(base));
                end
            end
        end

        // R3: bit positions of named flags via force one
        load_status(8'h00);
        apply(3'd3, 3'd7, 8'h00, 8'h00, 8'h00);
        check("R3 interrupt enable is bit 7", int'(status_o), 8'h80);
        load_status(8'h00);
        apply(3'd3, 3'd0, 8'h00, 8'h00, 8'h00);
        check("R3 carry is bit 0", int'(status_o), 8'h01);

        // R1: reset again from a nonzero word
        load_status(8'hFF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", int'(status_o), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule